// File: doc/BRIEF.md
# Single-Port RAM with Sequential Zero Sweep

This block is a single-clock, single-port synchronous memory of 512 words by 8 bits, written so that the storage array maps to dedicated block RAM. Block RAM cannot reset all of its words in one cycle. The block therefore clears its contents with a small state machine after every reset. That machine walks the address space from 0 upward and writes zero to one word per clock.

A user writes by raising `wr_en` with an address and data. A user reads by presenting an address with `wr_en` low, and the word appears on `rd_data` one clock later. `busy` is high while the sweep owns the array. During that time user writes are dropped and `rd_data` is held at zero.

The controller has two named states. CLEARING is entered on reset. Its transition, SWEEP_DONE, goes to READY on the clock edge that writes address 511. READY is left only through the transition RESTART, which is taken on reset and returns to CLEARING with the sweep pointer at 0.

Top module: `zeroing_ram`

## Requirements
- R1: In READY, a rising edge with `wr_en` high stores `wr_data` at `addr`. A later read of that address returns the stored word.
- R2: In READY, a rising edge with `wr_en` low loads `rd_data` with the word at `addr`, so the read has one cycle of latency.
- R3: In READY, `rd_data` keeps its value across an edge at which a write takes place.
- R4: `rd_data` is zero at power-up. It is also zero after every edge at which reset is high or the block is in CLEARING.
- R5: Reset is synchronous and active high. Any edge with `rst` high puts the block in CLEARING with `busy` high and sets the sweep pointer to 0, whether the block was in CLEARING or in READY.
- R6: After reset is released, the sweep writes zero to addresses 0, 1, …, 511 on successive edges. `busy` stays high for exactly 512 edges after the first edge with `rst` low.
- R7: Once `busy` falls, every one of the 512 locations reads back as zero.
- R8: While `busy` is high, a user write has no effect on the array.
- R9: CLEARING moves to READY (SWEEP_DONE) on the edge that writes address 511. READY is then held until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst | input | 1 | Synchronous active-high reset; starts a new sweep |
| wr_en | input | 1 | User write enable; ignored while busy |
| addr | input | 9 | Word address for user read or write |
| wr_data | input | 8 | User write data |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | High while the sweep is in progress (CLEARING) |

## Verification
The hardest condition to reach from the ports is a reset that lands part-way through a sweep. That restart is only visible as a sweep that runs its full 512 edges again from address 0.

The bench reaches it by counting edges after one reset release and pulsing `rst` for a single cycle at edge 100. It then counts `busy` edges again, expecting 512. It also fills the whole array with nonzero patterns first, so that a partial or skipped sweep shows up as nonzero readback. User writes are driven throughout each sweep to show that they are dropped.

// File: rtl/zram_pkg.sv
package zram_pkg;

    typedef enum logic {
        ST_CLEARING = 1'b0,
        ST_READY    = 1'b1
    } zr_state_e;

endpackage

// File: rtl/zram_sweeper.sv
module zram_sweeper
    import zram_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              sweep_active,
    output logic              sweep_we,
    output logic [ADDR_W-1:0] sweep_addr
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    zr_state_e         state_q, state_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;

    // next-state: SWEEP_DONE after the last address is written
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_CLEARING: begin
                ptr_d = ptr_q + 1'b1;
                if (ptr_q == LAST_ADDR) begin
                    state_d = ST_READY;
                end
            end
            ST_READY: begin
                state_d = ST_READY;
            end
        endcase
    end

    // state register; RESTART on reset from either state
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLEARING;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // outputs
    always_comb begin
        sweep_active = (state_q == ST_CLEARING);
        sweep_we     = (state_q == ST_CLEARING) && !rst;
        sweep_addr   = ptr_q;
    end

    p_restart_r5: assert property (@(posedge clk)
        rst |=> (state_q == ST_CLEARING && ptr_q == '0));

    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CLEARING && ptr_q != LAST_ADDR) |=> (state_q == ST_CLEARING && ptr_q == $past(ptr_q) + 1'b1));

    p_done_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CLEARING && ptr_q == LAST_ADDR) |=> state_q == ST_READY);

    p_ready_stays_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READY) |=> state_q == ST_READY);

endmodule

// File: rtl/zram_port_mux.sv
module zram_port_mux #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sweep_active,
    input  logic              sweep_we,
    input  logic [ADDR_W-1:0] sweep_addr,
    input  logic              usr_we,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic [DATA_W-1:0] usr_wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rd_load,
    output logic              rd_zero
);

    always_comb begin
        if (sweep_active) begin
            mem_we    = sweep_we;
            mem_addr  = sweep_addr;
            mem_wdata = '0;
        end else begin
            mem_we    = usr_we;
            mem_addr  = usr_addr;
            mem_wdata = usr_wdata;
        end
        rd_zero = rst || sweep_active;
        rd_load = !sweep_active && !usr_we;
    end

    p_sweep_owns_r8: assert property (@(posedge clk) disable iff (rst)
        sweep_active |-> (mem_we && mem_wdata == '0 && mem_addr == sweep_addr));

endmodule

// File: rtl/zram_array.sv
module zram_array #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_load,
    input  logic              rd_zero,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q = '0;

    // storage: no reset, one write port
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    // output register: may be forced to zero, loads only on non-write cycles
    always_ff @(posedge clk) begin
        if (rd_zero) begin
            rd_q <= '0;
        end else if (rd_load) begin
            rd_q <= mem[addr];
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/zeroing_ram.sv
module zeroing_ram #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);

    logic              sweep_active;
    logic              sweep_we;
    logic [ADDR_W-1:0] sweep_addr;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              rd_load;
    logic              rd_zero;

    zram_sweeper #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_sweep (
        .clk          (clk),
        .rst          (rst),
        .sweep_active (sweep_active),
        .sweep_we     (sweep_we),
        .sweep_addr   (sweep_addr)
    );

    zram_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .clk          (clk),
        .rst          (rst),
        .sweep_active (sweep_active),
        .sweep_we     (sweep_we),
        .sweep_addr   (sweep_addr),
        .usr_we       (wr_en),
        .usr_addr     (addr),
        .usr_wdata    (wr_data),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .rd_load      (rd_load),
        .rd_zero      (rd_zero)
    );

    zram_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .wr_en   (mem_we),
        .addr    (mem_addr),
        .wdata   (mem_wdata),
        .rd_load (rd_load),
        .rd_zero (rd_zero),
        .rdata   (rd_data)
    );

    assign busy = sweep_active;

    p_rd_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_en) |=> $stable(rd_data));

    p_busy_zero_r4: assert property (@(posedge clk)
        (busy || rst) |=> rd_data == '0);

    p_rst_busy_r5: assert property (@(posedge clk)
        rst |=> busy);

endmodule

// File: tb/tb_zeroing_ram.sv
`timescale 1ns/1ps
module tb_zeroing_ram;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       busy;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    zeroing_ram dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .busy    (busy)
    );

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'(((i * 37 + seed) % 255) + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive at negedge, result visible at the following negedge
    task automatic do_write(input int a, input logic [7:0] d);
        addr = 9'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int a, output logic [7:0] d);
        addr = 9'(a); wr_en = 1'b0;
        @(negedge clk);
        d = rd_data;
    endtask

    // release reset and count edges of busy while hammering user writes (R8)
    task automatic run_sweep(input string req, input int stop_at, output int n);
        rst = 1'b0;
        n = 0;
        do begin
            addr = 9'(n); wr_data = 8'hA5; wr_en = 1'b1;
            @(negedge clk);
            n++;
            if (busy) chk(rd_data == 8'h00, "R4 rd_data during sweep", rd_data, 0);
            if (n == stop_at) break;
        end while (busy && n < 2000);
        wr_en = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk); @(negedge clk);
        chk(busy == 1'b1, "R5 busy in reset", busy, 1);
        chk(rd_data == 8'h00, "R4 rd_data in reset", rd_data, 0);
    endtask

    task automatic t_first_sweep();
        int n;
        run_sweep("R6", 0, n);
        chk(n == 512, "R6 sweep length", n, 512);
        chk(busy == 1'b0, "R9 ready after sweep", busy, 0);
    endtask

    task automatic t_all_zero(input string req);
        logic [7:0] d;
        int bad = 0;
        for (int i = 0; i < 512; i++) begin
            do_read(i, d);
            if (d != 8'h00) begin
                bad++;
                if (bad < 4) chk(1'b0, req, d, 0);
            end
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic t_fill_and_check(input int seed);
        logic [7:0] d;
        int bad = 0;
        for (int i = 0; i < 512; i++) do_write(i, pat(i, seed));
        for (int i = 0; i < 512; i++) begin
            do_read(i, d);
            if (d != pat(i, seed)) begin
                bad++;
                if (bad < 4) chk(1'b0, "R1 R2 readback", d, pat(i, seed));
            end
        end
        chk(bad == 0, "R1 R2 pattern readback", bad, 0);
    endtask

    task automatic t_hold_on_write();
        logic [7:0] d;
        do_read(10, d);
        chk(d == pat(10, 3), "R2 read latency", d, pat(10, 3));
        do_write(20, 8'h3C);
        chk(rd_data == pat(10, 3), "R3 hold across write", rd_data, pat(10, 3));
        do_read(20, d);
        chk(d == 8'h3C, "R1 write then read", d, 8'h3C);
    endtask

    task automatic t_ready_stays();
        int drops = 0;
        for (int i = 0; i < 50; i++) begin
            do_write(i, 8'h11);
            if (busy) drops++;
        end
        chk(drops == 0, "R9 READY held", drops, 0);
    endtask

    task automatic t_reset_from_ready();
        int n;
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R5 reset from READY", busy, 1);
        chk(rd_data == 8'h00, "R4 zero after reset", rd_data, 0);
        run_sweep("R6", 0, n);
        chk(n == 512, "R6 sweep length after READY reset", n, 512);
    endtask

    task automatic t_restart_mid_sweep();
        int n;
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        run_sweep("R5", 100, n);
        chk(busy == 1'b1, "R5 busy mid-sweep", busy, 1);
        rst = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R5 busy after mid reset", busy, 1);
        run_sweep("R5", 0, n);
        chk(n == 512, "R5 restarted sweep length", n, 512);
    endtask

    initial begin
        #1;
        chk(rd_data == 8'h00, "R4 power-up", rd_data, 0);
        t_reset_state();
        t_first_sweep();
        t_all_zero("R8 user writes during sweep dropped");
        t_fill_and_check(3);
        t_hold_on_write();
        t_ready_stays();
        t_fill_and_check(91);
        t_reset_from_ready();
        t_all_zero("R7 all zero after reset from READY");
        t_fill_and_check(17);
        t_restart_mid_sweep();
        t_all_zero("R7 all zero after restarted sweep");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule